// File: doc/BRIEF.md
# Open-Drain Single-Wire Bus Master

This block is a byte-register-controlled master for a single-wire, open-drain serial bus. Software writes one start bit in the control register to run one bus operation. The operation is a reset pulse with presence detection, a time slot that writes a zero, or a time slot that writes a one and reads the line at the same time. While the operation runs, its start bit reads back as a busy flag. The bit clears itself when the operation ends, so software polls the control register to learn when the bus is free.

Every bus interval is counted in microseconds. The microsecond tick comes from a prescaler that software loads with the input clock frequency in MHz minus one. The block never drives the line high: it has only a pull-low enable. The line level comes back through a two-flop synchronizer. After a reset pulse, a status bit holds whether a device answered. After a write-one/read slot, a second status bit holds the line level sampled in that slot. The registers for byte transfer, command sequencing and interrupts are placeholders.

Top module: `owire_master`

## Requirements
- R1: Registers are byte wide at even byte offsets: control 0x00, divider 0x02, soft-reset placeholder 0x04, command 0x06, data 0x08, interrupt status 0x0A, interrupt enable 0x0C. The divider reads back the last value written while the bus was idle.
- R2: One microsecond of bus time lasts (divider + 1) clock cycles. It is counted from the clock edge that accepts the start.
- R3: Writing control bit 7 starts a reset operation. The line is pulled low for the first 480 µs. Bit 7 reads 1 for 960 µs and then reads 0.
- R4: Control bit 6 reads 1 when the line was low at the 550 µs point of the last reset operation, and 0 when it was high.
- R5: Writing control bit 5 starts a write-zero slot. The line is low for 60 µs and bit 5 reads 1 for 70 µs, which leaves at least 10 µs of released recovery.
- R6: Writing control bit 4 starts a write-one/read slot. The line is low for 6 µs and bit 4 reads 1 for 70 µs.
- R7: Control bit 3 holds the line level sampled 15 µs into the last write-one/read slot.
- R8: A write to the control register or the divider while any operation is busy has no effect.
- R9: When several start bits are written together, bit 7 wins over bit 5, and bit 5 wins over bit 4. A control write with none of bits 7, 5 or 4 set starts nothing.
- R10: The line is only ever pulled low, and only while an operation is busy. The line input is used only after two synchronizing flops.
- R11: The placeholder registers and odd offsets read 0x00 and ignore writes.
- R12: After reset, every register reads 0x00 and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Byte offset of register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| bus_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| bus_in | input | 1 | Sampled level of the line |

## Verification
A wrong microsecond counter or prescaler state appears at once as a pull-low edge or a busy-flag edge in the wrong cycle. The bench compares both on every clock against a model that counts cycles from the start edge. A corrupted operation state, such as a second start accepted while busy, shows in the very next cycle as the wrong busy bit or the wrong pull pattern. Sample-point errors are only visible after the operation finishes, when the presence or read-level bit holds the wrong value. The bench therefore reads these bits back after every operation, with the line held at both levels.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RST  = 2'd1,
    OP_WR0  = 2'd2,
    OP_WR1  = 2'd3
  } op_e;

  // control register bit positions (software-visible)
  localparam int CTRL_RST_BIT  = 7;
  localparam int CTRL_PRES_BIT = 6;
  localparam int CTRL_WR0_BIT  = 5;
  localparam int CTRL_WR1_BIT  = 4;
  localparam int CTRL_RDV_BIT  = 3;

  // byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_DIV  = 2;
  localparam int OFS_SRST = 4;
  localparam int OFS_CMD  = 6;
  localparam int OFS_DATA = 8;
  localparam int OFS_IST  = 10;
  localparam int OFS_IEN  = 12;

endpackage

// File: rtl/owire_prescaler.sv
module owire_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             at_end;

  assign at_end = (cnt_q == div_val);
  assign tick   = run && !clear && at_end;

  always_comb begin
    cnt_n = cnt_q;
    if (clear) begin
      cnt_n = '0;
    end else if (run) begin
      if (at_end) cnt_n = '0;
      else        cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_val));

endmodule

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RESET_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
#(
  parameter int RST_LOW_US = 480,
  parameter int RST_SMP_US = 550,
  parameter int RST_TOT_US = 960,
  parameter int WR0_LOW_US = 60,
  parameter int WR1_LOW_US = 6,
  parameter int RD_SMP_US  = 15,
  parameter int SLOT_US    = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       tick,
  input  logic       line_s,
  output logic       busy,
  output logic       accept,
  output logic       pull_low,
  output logic       rst_busy,
  output logic       wr0_busy,
  output logic       wr1_busy,
  output logic       presence,
  output logic       rd_level
);

  localparam int MAX_US = (RST_TOT_US > SLOT_US) ? RST_TOT_US : SLOT_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  localparam logic [US_W-1:0] RST_LOW_V  = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] RST_TOT_V  = US_W'(RST_TOT_US);
  localparam logic [US_W-1:0] RST_CAP_V  = US_W'(RST_SMP_US - 1);
  localparam logic [US_W-1:0] WR0_LOW_V  = US_W'(WR0_LOW_US);
  localparam logic [US_W-1:0] WR1_LOW_V  = US_W'(WR1_LOW_US);
  localparam logic [US_W-1:0] RD_CAP_V   = US_W'(RD_SMP_US - 1);
  localparam logic [US_W-1:0] SLOT_V     = US_W'(SLOT_US);

  op_e             op_q, op_n, req;
  logic [US_W-1:0] us_q, us_n;
  logic            pull_q, pull_n;
  logic            pres_q, pres_n;
  logic            rdv_q, rdv_n;
  logic            last_us;

  function automatic logic [US_W-1:0] low_of(input op_e o);
    case (o)
      OP_RST:  low_of = RST_LOW_V;
      OP_WR0:  low_of = WR0_LOW_V;
      OP_WR1:  low_of = WR1_LOW_V;
      default: low_of = '0;
    endcase
  endfunction

  function automatic logic [US_W-1:0] tot_of(input op_e o);
    case (o)
      OP_RST:  tot_of = RST_TOT_V;
      OP_WR0:  tot_of = SLOT_V;
      OP_WR1:  tot_of = SLOT_V;
      default: tot_of = '0;
    endcase
  endfunction

  // start-bit priority: reset, then write-zero, then write-one/read
  always_comb begin
    if      (ctrl_wdata[CTRL_RST_BIT]) req = OP_RST;
    else if (ctrl_wdata[CTRL_WR0_BIT]) req = OP_WR0;
    else if (ctrl_wdata[CTRL_WR1_BIT]) req = OP_WR1;
    else                               req = OP_IDLE;
  end

  assign busy    = (op_q != OP_IDLE);
  assign accept  = ctrl_wr && !busy && (req != OP_IDLE);
  assign last_us = (us_q == tot_of(op_q) - 1'b1);

  always_comb begin
    op_n   = op_q;
    us_n   = us_q;
    pres_n = pres_q;
    rdv_n  = rdv_q;
    if (accept) begin
      op_n = req;
      us_n = '0;
    end else if (busy && tick) begin
      if (op_q == OP_RST && us_q == RST_CAP_V) pres_n = ~line_s;
      if (op_q == OP_WR1 && us_q == RD_CAP_V)  rdv_n  = line_s;
      if (last_us) begin
        op_n = OP_IDLE;
        us_n = '0;
      end else begin
        us_n = us_q + 1'b1;
      end
    end
    pull_n = (op_n != OP_IDLE) && (us_n < low_of(op_n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      us_q   <= '0;
      pull_q <= 1'b0;
      pres_q <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      op_q   <= op_n;
      us_q   <= us_n;
      pull_q <= pull_n;
      pres_q <= pres_n;
      rdv_q  <= rdv_n;
    end
  end

  assign pull_low = pull_q;
  assign rst_busy = (op_q == OP_RST);
  assign wr0_busy = (op_q == OP_WR0);
  assign wr1_busy = (op_q == OP_WR1);
  assign presence = pres_q;
  assign rd_level = rdv_q;

  // R9
  rst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy && ctrl_wdata[CTRL_RST_BIT]) |=> rst_busy);

  // R10
  pull_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> ((op_q == $past(op_q)) || !busy));

  // R5
  recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!pull_low && !$past(pull_low)));

  // R3
  us_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (us_q < tot_of(op_q)));

endmodule

// File: rtl/owire_master.sv
module owire_master
  import owire_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DIV_W      = 8,
  parameter int SYNC_STG   = 2,
  parameter int RST_LOW_US = 480,
  parameter int RST_SMP_US = 550,
  parameter int RST_TOT_US = 960,
  parameter int WR0_LOW_US = 60,
  parameter int WR1_LOW_US = 6,
  parameter int RD_SMP_US  = 15,
  parameter int SLOT_US    = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              bus_pull_low,
  input  logic              bus_in
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);

  logic [DIV_W-1:0] div_q, div_n;
  logic             div_we, ctrl_we;
  logic             busy, accept, tick, line_s;
  logic             rst_busy, wr0_busy, wr1_busy, presence, rd_level;
  logic [7:0]       ctrl_rd;

  assign ctrl_we = reg_wr && (reg_addr == A_CTRL);
  assign div_we  = reg_wr && (reg_addr == A_DIV) && !busy;

  always_comb begin
    div_n = div_q;
    if (div_we) div_n = reg_wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  owire_sync #(
    .STAGES    (SYNC_STG),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (bus_in),
    .d_out (line_s)
  );

  owire_prescaler #(
    .DIV_W (DIV_W)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .clear   (accept),
    .div_val (div_q),
    .tick    (tick)
  );

  owire_slot_engine #(
    .RST_LOW_US (RST_LOW_US),
    .RST_SMP_US (RST_SMP_US),
    .RST_TOT_US (RST_TOT_US),
    .WR0_LOW_US (WR0_LOW_US),
    .WR1_LOW_US (WR1_LOW_US),
    .RD_SMP_US  (RD_SMP_US),
    .SLOT_US    (SLOT_US)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_we),
    .ctrl_wdata (reg_wdata),
    .tick       (tick),
    .line_s     (line_s),
    .busy       (busy),
    .accept     (accept),
    .pull_low   (bus_pull_low),
    .rst_busy   (rst_busy),
    .wr0_busy   (wr0_busy),
    .wr1_busy   (wr1_busy),
    .presence   (presence),
    .rd_level   (rd_level)
  );

  always_comb begin
    ctrl_rd                = '0;
    ctrl_rd[CTRL_RST_BIT]  = rst_busy;
    ctrl_rd[CTRL_PRES_BIT] = presence;
    ctrl_rd[CTRL_WR0_BIT]  = wr0_busy;
    ctrl_rd[CTRL_WR1_BIT]  = wr1_busy;
    ctrl_rd[CTRL_RDV_BIT]  = rd_level;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = ctrl_rd;
    else if (reg_addr == A_DIV) reg_rdata = 8'(div_q);
  end

  // R1
  div_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DIV && !busy) |=> (div_q == $past(reg_wdata[DIV_W-1:0])));

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(div_q));

  // R11
  stub_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != A_CTRL && reg_addr != A_DIV) |-> (reg_rdata == 8'h00));

endmodule

// File: tb/owire_master_tb.sv
`timescale 1ns/100ps
module owire_master_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       bus_pull_low;
  logic       bus_in;
  logic       slave_low = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // wired-AND line: master pull or device pull
  assign bus_in = !bus_pull_low && !slave_low;

  owire_master u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .bus_pull_low (bus_pull_low),
    .bus_in       (bus_in)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 4'd0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    reg_addr = 4'd0;
  endtask

  // cycle-by-cycle model: k = edges since the accepting edge
  task automatic run_op(input logic [7:0] cmd, input int low_us, input int tot_us,
                        input logic [7:0] bmask, input int d, input int inj_k,
                        input logic [3:0] inj_a, input logic [7:0] inj_d, input string tag);
    int span;
    logic exp_busy, exp_pull;
    span = tot_us * (d + 1);
    @(negedge clk);
    reg_addr = 4'd0; reg_wdata = cmd; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    for (int k = 0; k < span + 4; k++) begin
      #1;
      exp_busy = (k < span);
      exp_pull = exp_busy && ((k / (d + 1)) < low_us);
      chk({tag, " busy"}, reg_rdata & 8'hB0, exp_busy ? bmask : 8'h00);
      chk({tag, " pull"}, {7'd0, bus_pull_low}, {7'd0, exp_pull});
      if (k == inj_k) begin
        reg_addr = inj_a; reg_wdata = inj_d; reg_wr = 1'b1;
      end
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 4'd0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    #1;
    chk("R12 pull", {7'd0, bus_pull_low}, 8'h00);
    rst_n = 1'b1;
    for (int a = 0; a < 14; a += 2) rd_chk(4'(a), 8'h00, "R12");

    // R1 divider read back
    wr_reg(4'd2, 8'h01);
    rd_chk(4'd2, 8'h01, "R1");

    // R11 placeholders ignore writes
    for (int a = 4; a < 14; a += 2) wr_reg(4'(a), 8'hFF);
    for (int a = 4; a < 14; a += 2) rd_chk(4'(a), 8'h00, "R11");
    rd_chk(4'd1, 8'h00, "R11 odd");
    rd_chk(4'd0, 8'h00, "R11 ctrl");

    // R3/R4 reset with device answering, control write mid-op ignored (R8)
    slave_low = 1'b1;
    run_op(8'h80, 480, 960, 8'h80, 1, 100, 4'd0, 8'h20, "R3");
    rd_chk(4'd0, 8'h40, "R4 present");

    // R4 no device, divider write mid-op ignored (R8)
    slave_low = 1'b0;
    run_op(8'h80, 480, 960, 8'h80, 1, 200, 4'd2, 8'h07, "R3");
    rd_chk(4'd0, 8'h00, "R4 absent");
    rd_chk(4'd2, 8'h01, "R8 divider");

    // R6/R7 read slot, line high
    run_op(8'h10, 6, 70, 8'h10, 1, -1, 4'd0, 8'h00, "R6");
    rd_chk(4'd0, 8'h08, "R7 high");

    // R7 read slot, line held low by device
    slave_low = 1'b1;
    run_op(8'h10, 6, 70, 8'h10, 1, -1, 4'd0, 8'h00, "R6");
    rd_chk(4'd0, 8'h00, "R7 low");

    // R5 write-zero, reset request mid-slot ignored (R8)
    slave_low = 1'b0;
    run_op(8'h20, 60, 70, 8'h20, 1, 30, 4'd0, 8'h80, "R5");
    rd_chk(4'd0, 8'h00, "R8 after wr0");

    // R9 priority
    slave_low = 1'b1;
    run_op(8'hB0, 480, 960, 8'h80, 1, -1, 4'd0, 8'h00, "R9 rst");
    rd_chk(4'd0, 8'h40, "R9 rst stat");
    slave_low = 1'b0;
    run_op(8'h30, 60, 70, 8'h20, 1, -1, 4'd0, 8'h00, "R9 wr0");
    rd_chk(4'd0, 8'h40, "R9 wr0 stat");
    run_op(8'h18, 6, 70, 8'h10, 1, -1, 4'd0, 8'h00, "R9 wr1");
    rd_chk(4'd0, 8'h48, "R9 wr1 stat");

    // R2 other divider values
    wr_reg(4'd2, 8'h03);
    run_op(8'h20, 60, 70, 8'h20, 3, -1, 4'd0, 8'h00, "R2 d3");
    wr_reg(4'd2, 8'h00);
    run_op(8'h10, 6, 70, 8'h10, 0, -1, 4'd0, 8'h00, "R2 d0");
    rd_chk(4'd0, 8'h48, "R2 stat");

    // R9/R10 no start bit: nothing runs, line untouched while idle
    wr_reg(4'd0, 8'h4F);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      slave_low = i[0];
      #1;
      chk("R10 idle pull", {7'd0, bus_pull_low}, 8'h00);
      chk("R9 no start", reg_rdata, 8'h48);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule